// File: doc/BRIEF.md
# Programmable Skew Clock Output Bank

This block produces one true/complementary clock pair for a PLL-based clock driver. It runs from a fast clock at sixteen times the nominal VCO rate, so one fast-clock period is one time unit. A free-running phase counter modulo 16 stands in for the VCO cycle. The zero-skew clock is high during phases 0 to 7 and low during phases 8 to 15.

A 5-bit select code picks the output waveform. It can be a shift of the zero-skew clock by a whole number of time units, from -7 to +7, or the inverted clock, or the clock divided by 2 or by 4. The bank can be disabled or powered down. The disabled state is either tri-stated, with the driver enable `oe` dropped, or gated, with the pair parked at a chosen level. A master-reset input is asserted while every bank of the driver is off. It restarts the phase counter and the dividers, so all banks resume from the same known state.

Top module: `skew_bank`

## Requirements
- R1: While `rst` is high, `q`=0, `qn`=1 and `oe`=0. After the first rising edge with `rst` low, count rising edges k = 0, 1, 2, ... With select code 00000, `q` after edge k is 1 when (k mod 16) < 8 and 0 otherwise.
- R2: Codes 00001..00111 delay the waveform by 8-code time units (+7 down to +1). `q` after edge k is 1 when ((k - s) mod 16) < 8, where s = 8 - code.
- R3: Codes 01001..01111 advance the waveform by code-8 time units (-1 down to -7). The formula of R2 applies with s = -(code - 8).
- R4: Code 10000 gives the inverted clock: `q` is 1 when (k mod 16) >= 8.
- R5: Code 10001 gives a divide-by-2 clock and code 10010 a divide-by-4 clock. Both have 50% duty and change only on phase-0 edges. A divider count starts at 0 on restart and steps at each phase wrap. Divide-by-2 outputs count bit 0; divide-by-4 outputs count bit 1.
- R6: Every other code (for example 01000, 10011, 11111) behaves as code 00000.
- R7: A new select code is sampled only on the edge that ends phase 15, and on reset or master-reset edges. It takes effect from phase 0 onward.
- R8: `qn` is always the exact complement of `q`.
- R9: With `dis`=0 and `pwr_n`=1, `oe`=1 and the waveform is unaffected by `gate_mode` and `park_lvl`.
- R10: When `dis`=1 and `gate_mode`=0, `oe` is 0 after the next edge, and `q` keeps following the selected waveform.
- R11: When `dis`=1 and `gate_mode`=1, `oe` stays 1. `q` keeps running until the waveform reaches the parked level, then holds there. The parked level is `q`=1 when `park_lvl`=0 and `q`=0 when `park_lvl`=1. Releasing the disable resumes the waveform on the next edge.
- R12: `pwr_n`=0 acts exactly as `dis`=1, following the rules of R10 and R11.
- R13: While `all_off` is 1, the phase counter and divider count are held at 0 and the select code is reloaded each cycle. On release, the counting of R1 restarts at k = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, 16 periods per nominal VCO cycle |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 5 | Skew / invert / divide select code |
| dis | input | 1 | Bank disable (1 = disabled) |
| gate_mode | input | 1 | Disabled-state choice: 0 tri-state, 1 gated |
| park_lvl | input | 1 | Gated level: 0 parks `q` high, 1 parks `q` low |
| pwr_n | input | 1 | Power-down, active low |
| all_off | input | 1 | Master reset, asserted while every bank is disabled |
| q | output | 1 | True clock output |
| qn | output | 1 | Complementary clock output |
| oe | output | 1 | Driver enable (0 = outputs tri-stated) |

## Verification
The bench compares every cycle against a behavioural model. Each of the fifteen shift codes is covered, including the sign boundary at 01000. A design with a mirrored sign or an off-by-one shift shows a waveform displaced by one or more time units. Select codes are changed in mid-period: a design that switches at once, instead of at the phase wrap, emits a shortened pulse. Gated disable is entered while the output sits on the level opposite the park level, so a design that parks immediately produces a runt. Master reset is released with a divider selected: a design that keeps stale divider state comes out of restart in the wrong half-period.

// File: rtl/skew_pkg.sv
package skew_pkg;
  localparam int SEL_W = 5;
  localparam int SHIFT_W = 5;

  typedef enum logic [1:0] {W_SKEW, W_INV, W_DIV2, W_DIV4} wave_e;

  typedef struct packed {
    wave_e             kind;
    logic [SHIFT_W-1:0] shift; // two's complement time units
  } wave_cfg_t;

  function automatic wave_cfg_t decode_sel(input logic [SEL_W-1:0] c);
    wave_cfg_t d;
    d.kind  = W_SKEW;
    d.shift = '0;
    if (c[4:3] == 2'b00 && c[2:0] != 3'd0)
      d.shift = 5'd8 - {2'b00, c[2:0]};
    else if (c[4:3] == 2'b01 && c[2:0] != 3'd0)
      d.shift = 5'd0 - {2'b00, c[2:0]};
    else if (c == 5'b10000)
      d.kind = W_INV;
    else if (c == 5'b10001)
      d.kind = W_DIV2;
    else if (c == 5'b10010)
      d.kind = W_DIV4;
    return d;
  endfunction
endpackage

// File: rtl/skew_phase.sv
module skew_phase #(
  parameter int PH_BITS  = 4,
  parameter int DIV_BITS = 2,
  parameter int SEL_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mr,
  input  logic [SEL_W-1:0]    sel_in,
  output logic [PH_BITS-1:0]  ph,
  output logic [DIV_BITS-1:0] dcnt,
  output logic [SEL_W-1:0]    act_sel
);
  localparam logic [PH_BITS-1:0] LAST = '1;

  always_ff @(posedge clk) begin
    if (rst || mr) begin
      ph      <= '0;
      dcnt    <= '0;
      act_sel <= sel_in;
    end else begin
      ph <= ph + 1'b1;
      if (ph == LAST) begin
        act_sel <= sel_in;
        dcnt    <= dcnt + 1'b1;
      end
    end
  end

  AST_SEL_HOLD:  assert property (@(posedge clk) disable iff (rst)
    (!mr && ph != LAST) |=> $stable(act_sel)); // R7
  AST_PH_WRAP:   assert property (@(posedge clk) disable iff (rst)
    (!mr && ph == LAST) |=> (ph == '0)); // R1
  AST_DIV_STILL: assert property (@(posedge clk) disable iff (rst)
    (!mr && ph != LAST) |=> $stable(dcnt)); // R5
  AST_MR_CLEAR:  assert property (@(posedge clk) disable iff (rst)
    mr |=> (ph == '0 && dcnt == '0)); // R13
endmodule

// File: rtl/skew_wave.sv
module skew_wave import skew_pkg::*; #(
  parameter int PH_BITS  = 4,
  parameter int DIV_BITS = 2
) (
  input  logic [PH_BITS-1:0]  ph,
  input  logic [DIV_BITS-1:0] dcnt,
  input  wave_cfg_t           cfg,
  output logic                raw
);
  logic [PH_BITS-1:0] shifted;

  always_comb begin
    shifted = ph - cfg.shift[PH_BITS-1:0];
    unique case (cfg.kind)
      W_INV:   raw = ph[PH_BITS-1];
      W_DIV2:  raw = dcnt[0];
      W_DIV4:  raw = dcnt[1];
      default: raw = ~shifted[PH_BITS-1];
    endcase
  end
endmodule

// File: rtl/skew_gate.sv
module skew_gate (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  input  logic stop,
  input  logic gmode,
  input  logic park_lvl,
  output logic q,
  output logic qn,
  output logic oe
);
  logic park_q, want_gate, g_q, g_nxt;

  always_comb begin
    park_q    = ~park_lvl;
    want_gate = stop & gmode;
    g_nxt     = want_gate & (g_q | (raw == park_q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      g_q <= 1'b0;
      q   <= 1'b0;
      qn  <= 1'b1;
      oe  <= 1'b0;
    end else begin
      g_q <= g_nxt;
      q   <= g_nxt ? park_q : raw;
      qn  <= g_nxt ? park_lvl : ~raw;
      oe  <= ~(stop & ~gmode);
    end
  end

  AST_GATED_OE: assert property (@(posedge clk) disable iff (rst)
    g_q |-> oe); // R11
endmodule

// File: rtl/skew_bank.sv
module skew_bank import skew_pkg::*; #(
  parameter int PH_BITS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             dis,
  input  logic             gate_mode,
  input  logic             park_lvl,
  input  logic             pwr_n,
  input  logic             all_off,
  output logic             q,
  output logic             qn,
  output logic             oe
);
  localparam int DIV_BITS = 2;

  logic [PH_BITS-1:0]  ph;
  logic [DIV_BITS-1:0] dcnt;
  logic [SEL_W-1:0]    act_sel;
  wave_cfg_t           cfg;
  logic                raw, stop;

  skew_phase #(.PH_BITS(PH_BITS), .DIV_BITS(DIV_BITS), .SEL_W(SEL_W)) u_phase (
    .clk(clk), .rst(rst), .mr(all_off), .sel_in(sel),
    .ph(ph), .dcnt(dcnt), .act_sel(act_sel)
  );

  always_comb begin
    cfg  = decode_sel(act_sel);
    stop = dis | ~pwr_n;
  end

  skew_wave #(.PH_BITS(PH_BITS), .DIV_BITS(DIV_BITS)) u_wave (
    .ph(ph), .dcnt(dcnt), .cfg(cfg), .raw(raw)
  );

  skew_gate u_gate (
    .clk(clk), .rst(rst), .raw(raw), .stop(stop), .gmode(gate_mode),
    .park_lvl(park_lvl), .q(q), .qn(qn), .oe(oe)
  );
endmodule

// File: tb/tb_skew_bank.sv
module tb_skew_bank;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] sel = 5'd0;
  logic dis = 1'b0, gate_mode = 1'b0, park_lvl = 1'b0, pwr_n = 1'b1, all_off = 1'b0;
  logic q, qn, oe;

  int total = 0, bad = 0;
  string tag = "R1";
  bit started = 0, done = 0;

  int k = 0, dv = 0, msel = 0;
  bit mg = 0, eq = 0, eoe = 0;

  always #5 clk = ~clk;

  skew_bank dut (
    .clk(clk), .rst(rst), .sel(sel), .dis(dis), .gate_mode(gate_mode),
    .park_lvl(park_lvl), .pwr_n(pwr_n), .all_off(all_off),
    .q(q), .qn(qn), .oe(oe)
  );

  function automatic bit wave(int code, int kk, int d);
    int s = 0;
    if ((code >= 1 && code <= 7) || (code >= 9 && code <= 15)) s = 8 - code;
    if (code == 16) return (kk % 16) >= 8;
    if (code == 17) return (d % 2) == 1;
    if (code == 18) return ((d / 2) % 2) == 1;
    return ((((kk - s) % 16) + 16) % 16) < 8;
  endfunction

  task automatic check(bit ok, string r, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", r, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      eq = 0; eoe = 0; k = 0; dv = 0; msel = sel; mg = 0;
    end else begin
      bit w, st, mgn;
      w   = wave(msel, k, dv);
      st  = dis || !pwr_n;
      mgn = st && gate_mode && (mg || (w == !park_lvl));
      eq  = mgn ? !park_lvl : w;
      mg  = mgn;
      eoe = !(st && !gate_mode);
      if (all_off) begin
        k = 0; dv = 0; msel = sel;
      end else begin
        if (k == 15) begin msel = sel; dv = (dv + 1) % 4; end
        k = (k + 1) % 16;
      end
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      check(q == eq, tag, q, eq);
      check(qn == !eq, "R8", qn, !eq);
      check(oe == eoe, tag, oe, eoe);
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_up();
  end

  initial begin
    int highs;
    run(4);
    check(q == 0 && qn == 1 && oe == 0, "R1", {q, qn, oe}, 3'b010);
    rst = 1'b0;
    tag = "R1"; run(40);
    tag = "R2";
    for (int c = 1; c <= 7; c++) begin sel = 5'(c); run(32); end
    tag = "R3";
    for (int c = 9; c <= 15; c++) begin sel = 5'(c); run(32); end
    tag = "R4"; sel = 5'd16; run(32);
    tag = "R5"; sel = 5'd17; run(40);
    highs = 0;
    for (int i = 0; i < 32; i++) begin run(1); highs += int'(q); end
    check(highs == 16, "R5", highs, 16);
    sel = 5'd18; run(70);
    highs = 0;
    for (int i = 0; i < 64; i++) begin run(1); highs += int'(q); end
    check(highs == 32, "R5", highs, 32);
    tag = "R6";
    sel = 5'd8;  run(32);
    sel = 5'd19; run(32);
    sel = 5'd31; run(32);
    tag = "R7";
    sel = 5'd3;  run(5);
    sel = 5'd12; run(23);
    sel = 5'd16; run(9);
    sel = 5'd0;  run(30);
    tag = "R9";
    gate_mode = 1'b1; park_lvl = 1'b1; run(20);
    park_lvl = 1'b0; run(20);
    tag = "R10";
    gate_mode = 1'b0; sel = 5'd5; run(4); dis = 1'b1; run(30);
    tag = "R11";
    dis = 1'b0; run(3);
    gate_mode = 1'b1; park_lvl = 1'b0; dis = 1'b1; run(30);
    dis = 1'b0; run(13);
    park_lvl = 1'b1; dis = 1'b1; run(30);
    dis = 1'b0; run(20);
    sel = 5'd18; run(40); dis = 1'b1; run(70); dis = 1'b0; run(20);
    tag = "R12";
    pwr_n = 1'b0; gate_mode = 1'b0; run(30);
    gate_mode = 1'b1; park_lvl = 1'b0; run(40);
    pwr_n = 1'b1; run(20);
    tag = "R13";
    sel = 5'd17; dis = 1'b1; gate_mode = 1'b0; all_off = 1'b1; run(11);
    all_off = 1'b0; dis = 1'b0; run(2);
    check(q == 0, "R13", q, 0);
    run(50);
    sel = 5'd2; all_off = 1'b1; run(7); all_off = 1'b0; run(40);
    finish_up();
  end
endmodule